// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block sequences the column addresses of one memory burst. A one-cycle start request carries a full column address, a burst-length select and a burst-type select. The block captures them and emits one column address per clock for four or eight consecutive cycles. It marks the first beat and the last beat of each burst.

Only the three lowest column bits are reordered. The bits above them pass through unchanged on every beat. With sequential ordering, the lowest two bits count upward and wrap at four. For a length-8 burst, the sequencer finishes the starting four-beat group and then repeats the same low-bit pattern in the other group. With interleaved ordering, each offset is the starting offset XOR the beat number. A start request that arrives while a burst is running is dropped.

Top module: `burst_col_seq`

## Requirements
- R1: `burstLen8` is sampled with an accepted start: 0 selects 4 beats and 1 selects 8 beats. The beats appear on consecutive cycles, and `beatValid` falls in the cycle after the last beat.
- R2: `burstIlv` is sampled with an accepted start: 0 selects sequential order and 1 selects interleaved order. A change on `burstLen8`, `burstIlv` or `startCol` during a burst has no effect on that burst.
- R3: Sequential, length 4: on beat k, bits [1:0] equal (start[1:0] + k) mod 4, and bit 2 keeps its starting value. For example, start 2 gives 2,3,0,1.
- R4: Sequential, length 8: bits [1:0] equal (start[1:0] + k) mod 4. Bit 2 equals the start bit on beats 0-3 and its inverse on beats 4-7. For example, start 1 gives 1,2,3,0,5,6,7,4.
- R5: Interleaved, length 8: bits [2:0] equal start[2:0] XOR k. For example, start 5 gives 5,4,7,6,1,0,3,2.
- R6: Interleaved, length 4: bits [1:0] equal start[1:0] XOR k[1:0], and bit 2 keeps its starting value.
- R7: Column bits above bit 2 equal the captured start bits on every beat of the burst.
- R8: A start request is ignored while a burst is active, including in the cycle that shows the last beat.
- R9: The first beat appears in the cycle after the start is accepted and equals the start address, with `beatFirst` high. `beatLast` is high on beat 3 of a length-4 burst and on beat 7 of a length-8 burst, and only when `beatValid` is high.
- R10: While reset is asserted and after it is released, `beatValid` stays low until a start request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Start request, one cycle |
| startCol | input | COL_W | Starting column address |
| burstLen8 | input | 1 | 0: 4 beats, 1: 8 beats |
| burstIlv | input | 1 | 0: sequential, 1: interleaved |
| beatValid | output | 1 | A beat address is present |
| beatCol | output | COL_W | Column address of the current beat |
| beatFirst | output | 1 | Marks beat 0 |
| beatLast | output | 1 | Marks the final beat |

## Verification
The hardest case to reach from the ports is a start request that lands exactly on the last beat. There the control is about to go idle, so an off-by-one in the busy window would let a second burst begin. The stimulus keeps `startReq` high on every cycle from beat 1 through the last beat, with different address, length and type values each time. The scoreboard then treats any extra or altered beat as a failure. All 32 combinations of start offset, length and type run with random upper bits, which covers every ordering.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // width of the reordered low column field
  localparam int LOW_W = 3;

  typedef struct packed {
    logic load;   // capture a new burst
    logic step;   // advance to the next beat
  } seq_strobe_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int IDX_W = LOW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startReq,
  input  logic             len8In,
  output seq_strobe_t      strb,
  output logic             active,
  output logic [IDX_W-1:0] beatIdx,
  output logic             firstBeat,
  output logic             lastBeat
);
  localparam logic [IDX_W-1:0] LONG_LAST  = IDX_W'((1 << IDX_W) - 1);
  localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'((1 << (IDX_W - 1)) - 1);

  logic len8Q;

  assign lastBeat  = active && (beatIdx == (len8Q ? LONG_LAST : SHORT_LAST));
  assign firstBeat = active && (beatIdx == '0);

  always_comb begin
    strb.load = startReq && !active;
    strb.step = active && !lastBeat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      beatIdx <= '0;
      len8Q   <= 1'b0;
    end else if (strb.load) begin
      active  <= 1'b1;
      beatIdx <= '0;
      len8Q   <= len8In;
    end else if (strb.step) begin
      beatIdx <= beatIdx + 1'b1;
    end else if (lastBeat) begin
      active  <= 1'b0;
    end
  end
endmodule

// File: rtl/burst_seq_path.sv
module burst_seq_path
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int IDX_W = LOW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seq_strobe_t      strb,
  input  logic [COL_W-1:0] startCol,
  input  logic             len8In,
  input  logic             ilvIn,
  input  logic [IDX_W-1:0] beatIdx,
  output logic [COL_W-1:0] beatCol
);
  localparam int WRAP_W = IDX_W - 1;   // bits that wrap inside a group

  logic [COL_W-1:0] colQ;
  logic             len8Q;
  logic             ilvQ;
  logic [WRAP_W-1:0] wrapBits;
  logic              groupBit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      colQ  <= '0;
      len8Q <= 1'b0;
      ilvQ  <= 1'b0;
    end else if (strb.load) begin
      colQ  <= startCol;
      len8Q <= len8In;
      ilvQ  <= ilvIn;
    end
  end

  always_comb begin
    if (ilvQ) wrapBits = colQ[WRAP_W-1:0] ^ beatIdx[WRAP_W-1:0];
    else      wrapBits = colQ[WRAP_W-1:0] + beatIdx[WRAP_W-1:0];
    // the group bit flips on the second half of a long burst; in both
    // orderings that equals an XOR with the beat index top bit
    groupBit = len8Q ? (colQ[IDX_W-1] ^ beatIdx[IDX_W-1]) : colQ[IDX_W-1];
  end

  assign beatCol[IDX_W-1:0] = {groupBit, wrapBits};

  generate
    if (COL_W > IDX_W) begin : g_upper
      assign beatCol[COL_W-1:IDX_W] = colQ[COL_W-1:IDX_W];
    end
  endgenerate
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startReq,
  input  logic [COL_W-1:0] startCol,
  input  logic             burstLen8,
  input  logic             burstIlv,
  output logic             beatValid,
  output logic [COL_W-1:0] beatCol,
  output logic             beatFirst,
  output logic             beatLast
);
  seq_strobe_t      strb;
  logic [LOW_W-1:0] beatIdx;

  burst_seq_ctrl #(.IDX_W(LOW_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .startReq  (startReq),
    .len8In    (burstLen8),
    .strb      (strb),
    .active    (beatValid),
    .beatIdx   (beatIdx),
    .firstBeat (beatFirst),
    .lastBeat  (beatLast)
  );

  burst_seq_path #(.COL_W(COL_W), .IDX_W(LOW_W)) u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .startCol (startCol),
    .len8In   (burstLen8),
    .ilvIn    (burstIlv),
    .beatIdx  (beatIdx),
    .beatCol  (beatCol)
  );
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             startReq,
  input logic [COL_W-1:0] startCol,
  input logic             beatValid,
  input logic [COL_W-1:0] beatCol,
  input logic             beatFirst,
  input logic             beatLast
);
  p_first_is_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (startReq && !beatValid) |=> (beatValid && beatFirst && beatCol == $past(startCol)));

  p_last_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    beatLast |-> beatValid);

  p_busy_ignores_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (beatValid && !beatLast) |=> (beatValid && !beatFirst));

  p_ends_after_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
    beatLast |=> !beatValid);

  p_upper_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (beatValid && !beatLast) |=> (beatCol[COL_W-1:3] == $past(beatCol[COL_W-1:3])));

  p_idle_after_reset_r10: assert property (@(posedge clk)
    !rst_n |=> !beatValid);
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .startReq  (startReq),
  .startCol  (startCol),
  .beatValid (beatValid),
  .beatCol   (beatCol),
  .beatFirst (beatFirst),
  .beatLast  (beatLast)
);

// File: tb/tb_burst_col_seq.sv
module tb_burst_col_seq;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             startReq = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic             burstLen8 = 1'b0;
  logic             burstIlv = 1'b0;
  logic             beatValid;
  logic [COL_W-1:0] beatCol;
  logic             beatFirst;
  logic             beatLast;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [COL_W-1:0] col;
    logic             first;
    logic             last;
    string            tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .startCol(startCol),
    .burstLen8(burstLen8), .burstIlv(burstIlv), .beatValid(beatValid),
    .beatCol(beatCol), .beatFirst(beatFirst), .beatLast(beatLast)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] expOff(logic [2:0] s, int k, bit l8, bit il);
    logic [2:0] kk;
    logic [1:0] lo;
    logic       hi;
    kk = 3'(k);
    if (il) lo = s[1:0] ^ kk[1:0];
    else    lo = 2'((int'(s[1:0]) + k) % 4);
    if (!l8)     hi = s[2];
    else if (il) hi = s[2] ^ kk[2];
    else         hi = (k < 4) ? s[2] : ~s[2];
    return {hi, lo};
  endfunction

  // monitor: compare each produced beat with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && beatValid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R8", "unexpected beat", 32'(beatCol), 32'hx);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(beatCol[2:0] == e.col[2:0], e.tag, "low offset",
              32'(beatCol[2:0]), 32'(e.col[2:0]));
        check(beatCol[COL_W-1:3] == e.col[COL_W-1:3], "R7", "upper bits",
              32'(beatCol[COL_W-1:3]), 32'(e.col[COL_W-1:3]));
        check(beatFirst == e.first, "R9", "first flag", 32'(beatFirst), 32'(e.first));
        check(beatLast == e.last, "R9", "last flag", 32'(beatLast), 32'(e.last));
      end
    end
  end

  task automatic runBurst(input logic [COL_W-1:0] sc, input bit l8, input bit il,
                          input bit poke);
    int n;
    string tag;
    n = l8 ? 8 : 4;
    tag = l8 ? (il ? "R5" : "R4") : (il ? "R6" : "R3");
    @(negedge clk);
    startReq = 1'b1; startCol = sc; burstLen8 = l8; burstIlv = il;
    for (int k = 0; k < n; k++) begin
      exp_t e;
      e.col   = {sc[COL_W-1:3], expOff(sc[2:0], k, l8, il)};
      e.first = (k == 0);
      e.last  = (k == n - 1);
      e.tag   = tag;
      sb.push_back(e);
    end
    // beats show at the next n negedges; disturb inputs during them (R2, R8)
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      startReq  = poke;
      startCol  = COL_W'($urandom);
      burstLen8 = ~l8;
      burstIlv  = ~il;
    end
    @(negedge clk);
    startReq = 1'b0;
    #1;
    check(sb.size() == 0, "R1", "beats missing", 32'(sb.size()), 32'd0);
    check(beatValid == 1'b0, "R8", "valid after burst", 32'(beatValid), 32'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(beatValid == 1'b0, "R10", "valid in reset", 32'(beatValid), 32'd0);
    startReq = 1'b1;   // ignored under reset
    @(negedge clk);
    startReq = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(beatValid == 1'b0, "R10", "valid after reset", 32'(beatValid), 32'd0);

    // R3 R4 R5 R6: every start offset, length and type
    for (int l = 0; l < 2; l++)
      for (int t = 0; t < 2; t++)
        for (int s = 0; s < 8; s++)
          runBurst({7'($urandom), 3'(s)}, l[0], t[0], 1'b0);

    // R8: start held high through the whole burst, incl. the last beat
    for (int s = 0; s < 8; s++)
      runBurst({7'($urandom), 3'(s)}, s[0], s[1], 1'b1);

    // back-to-back with no idle gap between drive windows
    runBurst(10'h3F5, 1'b1, 1'b1, 1'b0);
    runBurst(10'h2A1, 1'b1, 1'b0, 1'b0);
    runBurst(10'h102, 1'b0, 1'b0, 1'b1);

    repeat (3) @(negedge clk);
    check(beatValid == 1'b0, "R10", "idle at end", 32'(beatValid), 32'd0);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule